// File: doc/BRIEF.md
# Search-Array Write Command Sequencer

This block is the device-side front end for host writes into a search-array chip. The host drives a 9-bit command bus with a valid strobe and a 68-bit bus that carries both address and data. A write takes four cycles. Two address half-cycles repeat the same write command, the next cycle carries the write data, and a mandatory idle cycle follows. The sequencer decodes the target, which is the data array, the mask array, external SRAM or the internal registers. It checks whether this device is addressed by its own ID or by the broadcast ID. It then resolves the write address, either directly from the bus or indirectly by merging the two low bus bits into one of eight segment registers.

The outputs are a registered write strobe with the target code, the resolved address, the data word and the global mask-register index. These drive the storage that sits behind the block. A device that is not addressed still follows the four-cycle sequence so that it stays aligned with the other devices on the bus. A command that arrives inside the data or idle cycle, or a second address cycle that lacks the write command, raises a one-cycle protocol-error pulse. The segment registers are loaded by register-target writes.

Top module: `srch_wr_seq`

## Requirements
- R1: A write starts when `cmd_vld`=1, `cmd[1:0]`=2'b01 and `cmd[2]`=0 in one cycle (A) and again in the next cycle (B). Any other command presented while the block is idle is ignored without error. If cycle B lacks the write command, the sequence is dropped, no strobe is issued, and `proto_err` is 1 in the following cycle.
- R2: The device is selected when `bus[25:21]` equals `dev_id` or equals 5'b11111, sampled in cycle B. A device that is not selected issues no strobe, leaves its outputs unchanged and still follows the full four-cycle timing.
- R3: `bus[20:19]` in cycle B selects the target, and `wr_tgt` reports the same code: 0 data array, 1 mask array, 2 external SRAM, 3 internal register.
- R4: Direct addressing (`bus[29]`=0) for an array target gives `wr_addr` = {8'b0, `bus[13:0]`}. For an SRAM target it gives `wr_addr` = {`cmd[8:6]`, 5'b0, `bus[13:0]`}.
- R5: Indirect addressing (`bus[29]`=1, array or SRAM target) uses segment register S, picked by `bus[28:26]`. The 14-bit address is {S[13:2], S[1]|`bus[1]`, S[0]|`bus[0]`}, padded into `wr_addr` as in R4.
- R6: A register target gives `wr_addr` = {16'b0, `bus[5:0]`}. For this target `bus[29]` and `bus[13:6]` are ignored.
- R7: `wr_gmr` is `cmd[5:3]` from cycle B for data-array and mask-array writes, and 0 for SRAM and register writes.
- R8: The bus value in the cycle after B appears on `wr_data`. `wr_stb` is 1 for exactly one cycle, the cycle after that data cycle. All outputs change only together with a strobe.
- R9: Any `cmd_vld`=1 in the data cycle or in the idle cycle is ignored and gives a one-cycle `proto_err` pulse in the next cycle. A write may start in the cycle right after the idle cycle.
- R10: Eight 14-bit segment registers reset to zero. A selected register write to address 0 to 7 loads register `wr_addr[2:0]` with `bus[13:0]` of the data cycle. A register write to any higher address, or to a device that is not selected, loads nothing.
- R11: During and right after reset, `wr_stb`, `proto_err`, `wr_addr`, `wr_data`, `wr_tgt` and `wr_gmr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_id | input | 5 | This device's ID |
| cmd_vld | input | 1 | Command bus valid strobe |
| cmd | input | 9 | Command: opcode [2:0], mask index [5:3], SRAM upper address [8:6] |
| bus | input | 68 | Shared address/data bus |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_tgt | output | 2 | Target code of the strobed write |
| wr_addr | output | 22 | Resolved write address |
| wr_data | output | 68 | Write data |
| wr_gmr | output | 3 | Global mask-register index |
| proto_err | output | 1 | One-cycle protocol-error pulse |

## Verification
The bench addresses the design with a matching ID, with the broadcast ID and with a foreign ID. A design that compared IDs wrongly would strobe on the foreign write or stay silent on the broadcast write. Indirect writes run first against the reset value of the segment registers and then against values loaded through register writes. Loads to register address 8 and loads to a device that is not selected must leave the registers untouched, and a decoder that kept only the low index bits would corrupt register 0. Commands are injected into the data cycle, into the idle cycle and as a missing B cycle. Wrong error timing, or a spurious restart that emits an extra strobe or a late error, is caught by checks on `proto_err` and by the scoreboard, which must be empty when the run ends.

// File: rtl/srch_wr_pkg.sv
package srch_wr_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDRB = 2'd1,
    S_DATA  = 2'd2,
    S_GAP   = 2'd3
  } wr_state_e;

  typedef enum logic [1:0] {
    T_DATA = 2'd0,
    T_MASK = 2'd1,
    T_SRAM = 2'd2,
    T_REG  = 2'd3
  } wr_tgt_e;

  // write opcode on cmd[1:0]; cmd[2] must be 0
  localparam logic [1:0] WR_OPC = 2'b01;

  // bus field positions decoded in the second address cycle
  localparam int IND_BIT = 29;
  localparam int SSR_LSB = 26;
  localparam int ID_LSB  = 21;
  localparam int TGT_LSB = 19;

endpackage

// File: rtl/srch_wr_fsm.sv
module srch_wr_fsm
  import srch_wr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_vld,
  input  logic [2:0] cmd_op,
  output wr_state_e st,
  output logic      cap_en,
  output logic      dat_en,
  output logic      proto_err
);

  wr_state_e st_d;
  logic      err_d;
  logic      is_wr;

  assign is_wr = cmd_vld && (cmd_op[1:0] == WR_OPC) && !cmd_op[2];

  always_comb begin
    st_d   = st;
    err_d  = 1'b0;
    cap_en = 1'b0;
    dat_en = 1'b0;
    case (st)
      S_IDLE: begin
        if (is_wr) st_d = S_ADDRB;
      end
      S_ADDRB: begin
        if (is_wr) begin
          st_d   = S_DATA;
          cap_en = 1'b1;
        end else begin
          st_d  = S_IDLE;
          err_d = 1'b1;
        end
      end
      S_DATA: begin
        st_d   = S_GAP;
        dat_en = 1'b1;
        err_d  = cmd_vld;
      end
      default: begin
        st_d  = S_IDLE;
        err_d = cmd_vld;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      proto_err <= 1'b0;
    end else begin
      st        <= st_d;
      proto_err <= err_d;
    end
  end

endmodule

// File: rtl/srch_wr_segbank.sv
module srch_wr_segbank #(
  parameter int SEG_N  = 8,
  parameter int ADDR_W = 14,
  localparam int SEG_IW = $clog2(SEG_N)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [SEG_IW-1:0]             ld_idx,
  input  logic [ADDR_W-1:0]             ld_val,
  output logic [SEG_N-1:0][ADDR_W-1:0]  seg_q
);

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    logic hit;
    assign hit = ld_en && (ld_idx == SEG_IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seg_q[g] <= '0;
      else if (hit) seg_q[g] <= ld_val;
    end
  end

endmodule

// File: rtl/srch_wr_dec.sv
module srch_wr_dec
  import srch_wr_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int ADDR_W = 14,
  parameter int SEG_N  = 8,
  parameter int OUT_AW = 22,
  parameter int SHI_W  = 3,
  parameter int GMR_W  = 3,
  parameter int REG_AW = 6,
  localparam int SEG_IW = $clog2(SEG_N),
  localparam int AB_W   = IND_BIT + 1,
  localparam int MID_W  = OUT_AW - SHI_W - ADDR_W,
  localparam int LO_PAD = OUT_AW - ADDR_W,
  localparam int RG_PAD = OUT_AW - REG_AW
) (
  input  logic [AB_W-1:0]               abus,
  input  logic [GMR_W-1:0]              gmr_in,
  input  logic [SHI_W-1:0]              shi_in,
  input  logic [ID_W-1:0]               dev_id,
  input  logic [SEG_N-1:0][ADDR_W-1:0]  seg_q,
  output logic                          sel,
  output logic [1:0]                    tgt,
  output logic [OUT_AW-1:0]             addr,
  output logic [GMR_W-1:0]              gmr
);

  logic [ID_W-1:0]   id_f;
  logic [SEG_IW-1:0] ssr;
  logic [ADDR_W-1:0] seg_pick;
  logic [ADDR_W-1:0] a_loc;
  wr_tgt_e           t;
  wire               unused_rsvd = ^abus[TGT_LSB-1:ADDR_W];

  assign id_f     = abus[ID_LSB +: ID_W];
  assign sel      = (id_f == dev_id) || (id_f == {ID_W{1'b1}});
  assign t        = wr_tgt_e'(abus[TGT_LSB +: 2]);
  assign tgt      = t;
  assign ssr      = abus[SSR_LSB +: SEG_IW];
  assign seg_pick = seg_q[ssr];
  assign a_loc    = abus[IND_BIT] ? (seg_pick | {{(ADDR_W-2){1'b0}}, abus[1:0]})
                                  : abus[ADDR_W-1:0];

  always_comb begin
    gmr = '0;
    case (t)
      T_DATA, T_MASK: begin
        addr = {{LO_PAD{1'b0}}, a_loc};
        gmr  = gmr_in;
      end
      T_SRAM:  addr = {shi_in, {MID_W{1'b0}}, a_loc};
      default: addr = {{RG_PAD{1'b0}}, abus[REG_AW-1:0]};
    endcase
  end

endmodule

// File: rtl/srch_wr_seq.sv
module srch_wr_seq
  import srch_wr_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int BUS_W  = 68,
  parameter int ADDR_W = 14,
  parameter int SEG_N  = 8,
  parameter int OUT_AW = 22,
  parameter int SHI_W  = 3,
  parameter int GMR_W  = 3,
  parameter int REG_AW = 6,
  localparam int SEG_IW = $clog2(SEG_N),
  localparam int CMD_W  = 3 + GMR_W + SHI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [BUS_W-1:0]  bus,
  output logic              wr_stb,
  output logic [1:0]        wr_tgt,
  output logic [OUT_AW-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data,
  output logic [GMR_W-1:0]  wr_gmr,
  output logic              proto_err
);

  wr_state_e st;
  logic      cap_en, dat_en;

  logic              dec_sel;
  logic [1:0]        dec_tgt;
  logic [OUT_AW-1:0] dec_addr;
  logic [GMR_W-1:0]  dec_gmr;
  logic [SEG_N-1:0][ADDR_W-1:0] seg_q;

  logic              sel_q;
  logic [1:0]        tgt_q;
  logic [OUT_AW-1:0] addr_q;
  logic [GMR_W-1:0]  gmr_q;
  logic              stb_d, ld_en;

  srch_wr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld   (cmd_vld),
    .cmd_op    (cmd[2:0]),
    .st        (st),
    .cap_en    (cap_en),
    .dat_en    (dat_en),
    .proto_err (proto_err)
  );

  srch_wr_dec #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .SEG_N(SEG_N), .OUT_AW(OUT_AW),
    .SHI_W(SHI_W), .GMR_W(GMR_W), .REG_AW(REG_AW)
  ) u_dec (
    .abus   (bus[IND_BIT:0]),
    .gmr_in (cmd[3 +: GMR_W]),
    .shi_in (cmd[3+GMR_W +: SHI_W]),
    .dev_id (dev_id),
    .seg_q  (seg_q),
    .sel    (dec_sel),
    .tgt    (dec_tgt),
    .addr   (dec_addr),
    .gmr    (dec_gmr)
  );

  // segment load happens with the data cycle of a selected register write
  assign ld_en = dat_en && sel_q && (tgt_q == T_REG)
              && (addr_q[REG_AW-1:SEG_IW] == '0);

  srch_wr_segbank #(.SEG_N(SEG_N), .ADDR_W(ADDR_W)) u_seg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_idx (addr_q[SEG_IW-1:0]),
    .ld_val (bus[ADDR_W-1:0]),
    .seg_q  (seg_q)
  );

  // address-phase capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      tgt_q  <= '0;
      addr_q <= '0;
      gmr_q  <= '0;
    end else if (cap_en) begin
      sel_q  <= dec_sel;
      tgt_q  <= dec_tgt;
      addr_q <= dec_addr;
      gmr_q  <= dec_gmr;
    end
  end

  assign stb_d = dat_en && sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_stb <= 1'b0;
    else        wr_stb <= stb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tgt  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_gmr  <= '0;
    end else if (stb_d) begin
      wr_tgt  <= tgt_q;
      wr_addr <= addr_q;
      wr_data <= bus;
      wr_gmr  <= gmr_q;
    end
  end

endmodule

// File: rtl/srch_wr_chk.sv
module srch_wr_chk
  import srch_wr_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input wr_state_e st,
  input logic      cmd_vld,
  input logic      wr_stb,
  input logic      proto_err
);

  // R8: strobe never lasts two cycles
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8: strobe only in the cycle after the data cycle
  a_r8_stb_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(st) == S_DATA);

  // R1: data cycle always follows a second address cycle
  a_r1_data_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> $past(st) == S_ADDRB);

  // R9: data cycle is always followed by the idle cycle
  a_r9_data_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |=> (st == S_GAP));

  // R9: nothing can start inside the idle cycle
  a_r9_gap_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |=> (st == S_IDLE));

  // R9: command in the idle cycle flags an error
  a_r9_gap_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && cmd_vld) |=> proto_err);

endmodule

bind srch_wr_seq srch_wr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st),
  .cmd_vld   (cmd_vld),
  .wr_stb    (wr_stb),
  .proto_err (proto_err)
);

// File: tb/srch_wr_seq_tb.sv
module srch_wr_seq_tb;

  localparam logic [4:0] DEV = 5'h0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [8:0]  cmd = '0;
  logic [67:0] bus = '0;
  logic        wr_stb, proto_err;
  logic [1:0]  wr_tgt;
  logic [21:0] wr_addr;
  logic [67:0] wr_data;
  logic [2:0]  wr_gmr;

  always #10 clk = ~clk;

  srch_wr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(DEV), .cmd_vld(cmd_vld), .cmd(cmd),
    .bus(bus), .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_gmr(wr_gmr), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [1:0]  tgt;
    logic [21:0] addr;
    logic [2:0]  gmr;
    logic [67:0] data;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0, n_exp = 0, n_seen = 0;
  logic [13:0] seg_m [8];

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as strobes appear
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      n_seen++;
      if (q.size() == 0) begin
        chk("R2 unexpected strobe", 68'd1, 68'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R3 target", {66'd0, wr_tgt}, {66'd0, e.tgt});
        chk("R4 R5 R6 address", {46'd0, wr_addr}, {46'd0, e.addr});
        chk("R7 mask index", {65'd0, wr_gmr}, {65'd0, e.gmr});
        chk("R8 data", wr_data, e.data);
      end
    end
  end

  function automatic logic [67:0] mk_addr(input logic [4:0] id, input logic [1:0] tgt,
      input logic ind, input logic [2:0] ssr, input logic [13:0] low);
    logic [67:0] b;
    b = {68{1'b1}};
    b[29] = ind; b[28:26] = ssr; b[25:21] = id; b[20:19] = tgt; b[13:0] = low;
    return b;
  endfunction

  // inj: 0 none, 1 command in data cycle, 2 command in idle cycle
  task automatic wr(input logic [4:0] id, input logic [1:0] tgt, input logic ind,
      input logic [2:0] ssr, input logic [13:0] low, input logic [2:0] gmr,
      input logic [2:0] shi, input logic [67:0] data, input int inj);
    logic [8:0]  c;
    logic [13:0] a14;
    exp_t        e;
    bit          sel;
    c = {shi, gmr, 1'b0, 2'b01};
    @(negedge clk); cmd_vld = 1'b1; cmd = c; bus = mk_addr(id, tgt, ind, ssr, low);
    @(negedge clk);
    sel = (id == DEV) || (id == 5'h1F);
    a14 = ind ? (seg_m[ssr] | {12'd0, low[1:0]}) : low;
    e.tgt  = tgt;
    e.data = data;
    e.gmr  = (tgt < 2) ? gmr : 3'd0;
    case (tgt)
      2'd0, 2'd1: e.addr = {8'd0, a14};
      2'd2:       e.addr = {shi, 5'd0, a14};
      default:    e.addr = {16'd0, low[5:0]};
    endcase
    if (sel) begin
      q.push_back(e);
      n_exp++;
      if (tgt == 2'd3 && low[5:3] == 3'd0) seg_m[low[2:0]] = data[13:0];
    end
    @(negedge clk); cmd_vld = (inj == 1); cmd = (inj == 1) ? c : 9'd0; bus = data;
    @(negedge clk); cmd_vld = (inj == 2); cmd = (inj == 2) ? c : 9'd0; bus = ~data;
    chk("R9 error flag in idle cycle", {67'd0, proto_err}, {67'd0, inj == 1});
    if (inj == 2) begin
      @(negedge clk); cmd_vld = 1'b0; cmd = '0;
      chk("R9 error after idle-cycle command", {67'd0, proto_err}, 68'd1);
      @(negedge clk);
      chk("R9 idle-cycle command not started", {67'd0, proto_err}, 68'd0);
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) seg_m[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 strobe in reset", {67'd0, wr_stb}, 68'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 strobe after reset", {67'd0, wr_stb}, 68'd0);
    chk("R11 error after reset", {67'd0, proto_err}, 68'd0);
    chk("R11 address after reset", {46'd0, wr_addr}, 68'd0);
    chk("R11 data after reset", wr_data, 68'd0);

    // R4 R7 direct writes, back to back
    wr(DEV, 2'd0, 1'b0, 3'd0, 14'h1234, 3'd5, 3'd0, 68'hA_1111_2222_3333_4444, 0);
    wr(DEV, 2'd1, 1'b0, 3'd7, 14'h3ABC, 3'd2, 3'd0, 68'h5_0F0F_0F0F_0F0F_0F0F, 0);
    wr(DEV, 2'd2, 1'b0, 3'd0, 14'h0FED, 3'd4, 3'd6, 68'h0_DEAD_BEEF_0000_0001, 0);
    // R5 R10 indirect from reset-zero segment
    wr(DEV, 2'd0, 1'b1, 3'd3, 14'h3FF2, 3'd1, 3'd0, 68'h1_2345_6789_ABCD_EF01, 0);
    // R10 segment loads, broadcast ID; R6 indirect bit ignored for register
    wr(5'h1F, 2'd3, 1'b0, 3'd0, {8'hFF, 6'd5}, 3'd3, 3'd0, 68'h0_0000_0000_0000_1A3C, 0);
    wr(DEV, 2'd3, 1'b1, 3'd6, {8'hFF, 6'd2}, 3'd0, 3'd0, 68'h0_0000_0000_0000_2C81, 0);
    // R5 indirect with loaded segments
    wr(DEV, 2'd1, 1'b1, 3'd5, 14'h0001, 3'd6, 3'd0, 68'h3_3333_3333_3333_3333, 0);
    wr(DEV, 2'd2, 1'b1, 3'd2, 14'h2003, 3'd0, 3'd3, 68'h7_7777_0000_7777_0000, 0);
    // R10 register address 8 must not touch segment 0
    wr(DEV, 2'd3, 1'b0, 3'd0, 14'd8, 3'd0, 3'd0, 68'h0_0000_0000_0000_3FFF, 0);
    // R2 foreign ID: no strobe, no segment load
    wr(5'h03, 2'd0, 1'b0, 3'd0, 14'h0042, 3'd1, 3'd0, 68'hF_FFFF_FFFF_FFFF_FFFF, 0);
    wr(5'h03, 2'd3, 1'b0, 3'd0, 14'd0, 3'd0, 3'd0, 68'h0_0000_0000_0000_1111, 0);
    wr(DEV, 2'd0, 1'b1, 3'd0, 14'h0000, 3'd7, 3'd0, 68'h2_2222_2222_2222_2222, 0);
    // R9 commands in data cycle and idle cycle
    wr(DEV, 2'd1, 1'b0, 3'd0, 14'h0100, 3'd1, 3'd0, 68'h9_9999_9999_9999_9999, 1);
    wr(DEV, 2'd0, 1'b0, 3'd0, 14'h0200, 3'd2, 3'd0, 68'h8_8888_8888_8888_8888, 2);
    wr(5'h1F, 2'd0, 1'b0, 3'd0, 14'h0300, 3'd3, 3'd0, 68'h6_6666_6666_6666_6666, 0);

    // R1 missing second address cycle
    @(negedge clk); cmd_vld = 1'b1; cmd = 9'b000_000_001; bus = mk_addr(DEV, 2'd0, 1'b0, 3'd0, 14'h5);
    @(negedge clk); cmd_vld = 1'b0; cmd = '0;
    @(negedge clk);
    chk("R1 error on missing B cycle", {67'd0, proto_err}, 68'd1);
    @(negedge clk);
    chk("R1 error pulse ends", {67'd0, proto_err}, 68'd0);
    // R1 non-write command ignored without error
    @(negedge clk); cmd_vld = 1'b1; cmd = 9'b000_000_110;
    @(negedge clk); cmd_vld = 1'b1; cmd = 9'b000_000_110;
    @(negedge clk); cmd_vld = 1'b0; cmd = '0;
    chk("R1 non-write no error", {67'd0, proto_err}, 68'd0);
    repeat (6) @(negedge clk);
    chk("R2 R8 strobe count", 68'(n_seen), 68'(n_exp));
    chk("R2 scoreboard drained", 68'(q.size()), 68'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule